// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between an on-chip requester and an external asynchronous 256K x 16 static RAM. It turns single-word read and write requests into select, output-enable, write-enable and byte-strobe sequences. Every minimum time is held by counting clock cycles. The host side uses a request/ready handshake with an 18-bit word address, 16-bit write data and two byte enables. Read data comes back with a one-cycle valid strobe. On the memory side the data bus is split into an output value, an input value and an output-enable, so the pad driver stays outside the block.

Timing minimums are given in nanoseconds together with the clock period, and are rounded up to whole cycles. With the default 10 ns clock, a read or write access lasts 6 cycles and the write-enable pulse lasts 4 cycles. A read is always followed by 2 turnaround cycles before the controller can drive the bus again. A separate level request puts the memory into low-power retention by pulling the active-high select low. When the request is dropped, the controller waits one read-cycle time before it accepts the next access.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, it drives mem_cs_n_o=1, mem_cs_o=1, mem_oe_n_o=1, mem_we_n_o=1, mem_ub_n_o=1, mem_lb_n_o=1 and mem_dq_oe_o=0, and rvalid_o=0.
- R2: A read accepted on a clock edge where req_i and ready_o are both high drives mem_cs_n_o=0, mem_cs_o=1, mem_oe_n_o=0 and mem_we_n_o=1 for exactly 6 cycles, starting in the next cycle. During these cycles mem_ub_n_o is the inverse of be_i[1] and mem_lb_n_o is the inverse of be_i[0]; bit 1 covers data bits 15:8 and bit 0 covers bits 7:0.
- R3: An accepted write drives the same select and strobe values for exactly 6 cycles, with mem_oe_n_o=1. mem_we_n_o is low only in cycles 2 to 5 of those 6. With both byte enables zero, no byte of the memory changes.
- R4: mem_dq_oe_o is high exactly during the 6 write cycles and never while mem_oe_n_o is low. During those cycles mem_dq_o equals the accepted write data.
- R5: Read data is taken from mem_dq_i in the last read cycle. Bytes whose enable is zero read as 0. rvalid_o is high for exactly the one cycle that follows the last read cycle, and rdata_o is valid in that cycle.
- R6: Every read is followed by 2 turnaround cycles in which the chip is deselected, the bus is not driven and ready_o is low.
- R7: mem_addr_o and the byte strobes hold the accepted address and byte enables, unchanged, for the whole access.
- R8: ready_o is high only while idle with no retention request. A request made while ready_o is low has no effect.
- R9: A high ret_req_i seen while idle makes the controller drive mem_cs_o=0 and mem_cs_n_o=1 from the next cycle on. ready_o stays low for as long as ret_req_i stays high. If ret_req_i rises during an access, retention is entered only once the controller is idle again.
- R10: After ret_req_i falls, the controller spends 6 recovery cycles deselected with mem_cs_o=1 and ready_o low, and then returns to idle.
- R11: When req_i and ret_req_i are both high while idle, retention wins. ready_o is low in that cycle and the request is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables, bit 1 = upper byte |
| ready_o | output | 1 | Controller can accept a request |
| rdata_o | output | 16 | Read data |
| rvalid_o | output | 1 | Read data valid, one-cycle pulse |
| ret_req_i | input | 1 | Retention request, level |
| mem_cs_n_o | output | 1 | Active-low chip select |
| mem_cs_o | output | 1 | Active-high chip select |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_ub_n_o | output | 1 | Upper byte strobe, active low |
| mem_lb_n_o | output | 1 | Lower byte strobe, active low |
| mem_addr_o | output | 18 | Memory address |
| mem_dq_o | output | 16 | Data to memory |
| mem_dq_i | input | 16 | Data from memory |
| mem_dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
A host request and a retention request can arrive in the same idle cycle. The bench provokes this by raising req_i and ret_req_i on the same edge. It then expects ready_o to be low in that cycle, the chip to go into retention, and the still-pending request to be served only after the recovery wait has counted out. A second collision is a retention request raised in the middle of a read. For this case the reference model expects the read, its valid pulse and its turnaround to finish untouched before the select is pulled low. A behavioural model of the memory stores bytes under the write strobe and returns filler bytes on disabled lanes, so masking and byte writes are judged by later read-back.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  localparam int DQ_W   = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DQ_W / LANE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WRITE,
    ST_RET,
    ST_RECOV
  } ctrl_state_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction
endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // counter must never be reloaded while a previous count is still running
  p_load_when_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> zero_o);
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    active_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [LANES*LANE_W-1:0] raw_i,
  output logic [LANES-1:0]        strb_n_o,
  output logic [LANES*LANE_W-1:0] masked_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign strb_n_o[l] = ~(active_i & be_i[l]);
    assign masked_o[l*LANE_W +: LANE_W] = be_i[l] ? raw_i[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int CLK_NS    = 10,
  parameter int T_RC_NS   = 55,
  parameter int T_WC_NS   = 55,
  parameter int T_WP_NS   = 40,
  parameter int T_RDR_NS  = 55,
  parameter int TURN_CYC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        be_i,
  output logic              ready_o,
  output logic [15:0]       rdata_o,
  output logic              rvalid_o,
  input  logic              ret_req_i,
  output logic              mem_cs_n_o,
  output logic              mem_cs_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic              mem_ub_n_o,
  output logic              mem_lb_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_dq_o,
  input  logic [15:0]       mem_dq_i,
  output logic              mem_dq_oe_o
);
  localparam int RC_CYC  = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int WP_CYC  = ns_to_cyc(T_WP_NS, CLK_NS);
  // one setup and one hold cycle around the strobe
  localparam int WR_CYC  = (ns_to_cyc(T_WC_NS, CLK_NS) > WP_CYC + 2) ?
                           ns_to_cyc(T_WC_NS, CLK_NS) : WP_CYC + 2;
  localparam int RDR_CYC = ns_to_cyc(T_RDR_NS, CLK_NS);
  localparam int MAX_A   = (RC_CYC > WR_CYC) ? RC_CYC : WR_CYC;
  localparam int MAX_B   = (RDR_CYC > TURN_CYC) ? RDR_CYC : TURN_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   wdata_q, rdata_q;
  logic [LANES-1:0]  be_q, strb_n;
  logic [DQ_W-1:0]   rd_masked;
  logic              rvalid_q;
  logic              accept, tmr_load, tmr_zero, capture;
  logic [CNT_W-1:0]  tmr_val;
  logic [CNT_W-1:0]  wr_left;
  logic              access;

  assign ready_o = (state_q == ST_IDLE) && !ret_req_i;
  assign accept  = req_i && ready_o;
  assign capture = (state_q == ST_READ) && tmr_zero;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (ret_req_i) begin
          state_d = ST_RET;
        end else if (req_i) begin
          state_d  = we_i ? ST_WRITE : ST_READ;
          tmr_load = 1'b1;
          tmr_val  = we_i ? CNT_W'(WR_CYC - 1) : CNT_W'(RC_CYC - 1);
        end
      end
      ST_READ: if (tmr_zero) begin
        state_d  = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TURN_CYC - 1);
      end
      ST_TURN, ST_WRITE, ST_RECOV: if (tmr_zero) state_d = ST_IDLE;
      ST_RET: if (!ret_req_i) begin
        state_d  = ST_RECOV;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RDR_CYC - 1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= capture;
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_i;
      end
      if (capture) rdata_q <= rd_masked;
    end
  end

  sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  // the write countdown is tracked here to place the strobe window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              wr_left <= '0;
    else if (accept && we_i)                  wr_left <= CNT_W'(WR_CYC - 1);
    else if (state_q == ST_WRITE && wr_left != '0) wr_left <= wr_left - 1'b1;
  end

  assign access = (state_q == ST_READ) || (state_q == ST_WRITE);

  sram_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) u_map (
    .active_i (access),
    .be_i     (be_q),
    .raw_i    (mem_dq_i),
    .strb_n_o (strb_n),
    .masked_o (rd_masked)
  );

  assign mem_cs_n_o  = !access;
  assign mem_cs_o    = (state_q != ST_RET);
  assign mem_oe_n_o  = (state_q != ST_READ);
  assign mem_we_n_o  = !((state_q == ST_WRITE) &&
                         (wr_left <= CNT_W'(WR_CYC - 2)) &&
                         (wr_left >= CNT_W'(WR_CYC - 1 - WP_CYC)));
  assign mem_ub_n_o  = strb_n[1];
  assign mem_lb_n_o  = strb_n[0];
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = (state_q == ST_WRITE);
  assign rdata_o     = rdata_q;
  assign rvalid_o    = rvalid_q;

  p_no_contention_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);

  p_we_selected_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_cs_n_o && mem_cs_o && mem_oe_n_o && mem_dq_oe_o));

  p_rvalid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  p_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_n_o && $past(!mem_cs_n_o)) |->
      ($stable(mem_addr_o) && $stable({mem_ub_n_o, mem_lb_n_o})));

  p_turn_before_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> ($past(mem_oe_n_o) && $past(mem_oe_n_o, 2)));

  p_ready_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_cs_n_o && mem_oe_n_o && !mem_dq_oe_o && !ret_req_i));

  p_ret_deselect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs_o |-> (mem_cs_n_o && !ready_o && !mem_dq_oe_o));

  p_recov_after_ret_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_cs_o) |-> !ready_o);
endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
  localparam int RC = 6, WRC = 6, WP = 4, TA = 2, RDR = 6;
  localparam int M_IDLE = 0, M_RD = 1, M_TURN = 2, M_WR = 3, M_RET = 4, M_REC = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, ret_req = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic ready_o, rvalid_o, cs_n, cs, oe_n, we_n, ub_n, lb_n, dq_oe;
  logic [15:0] rdata_o, dq_o, dq_i;
  logic [17:0] maddr;

  logic [15:0] mem_arr [64];
  int n_cmp = 0, n_bad = 0, cycles = 0;

  always #5 clk = ~clk;

  assign dq_i = (!cs_n && cs && !oe_n) ?
                {ub_n ? 8'hA5 : mem_arr[maddr[5:0]][15:8],
                 lb_n ? 8'h5A : mem_arr[maddr[5:0]][7:0]} : 16'hC3C3;

  sram_lane_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .ret_req_i(ret_req), .mem_cs_n_o(cs_n), .mem_cs_o(cs),
    .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_ub_n_o(ub_n), .mem_lb_n_o(lb_n),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_i(dq_i), .mem_dq_oe_o(dq_oe)
  );

  // reference model
  int m_mode = M_IDLE, m_el = 0;
  bit m_acc = 0, m_rv = 0;
  logic [17:0] c_addr;
  logic [15:0] c_wd, m_rd;
  logic [1:0]  c_be;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = M_IDLE; m_el = 0; m_acc = 0; m_rv = 0;
    end else begin
      m_acc = 0; m_rv = 0;
      case (m_mode)
        M_IDLE: if (ret_req) m_mode = M_RET;
                else if (req) begin
                  m_acc = 1; c_addr = addr; c_wd = wdata; c_be = be;
                  m_mode = we ? M_WR : M_RD; m_el = 0;
                end
        M_RD: if (m_el == RC - 1) begin
                m_rd = mem_arr[c_addr[5:0]] & {{8{c_be[1]}}, {8{c_be[0]}}};
                m_rv = 1; m_mode = M_TURN; m_el = 0;
              end else m_el++;
        M_TURN: if (m_el == TA - 1) m_mode = M_IDLE; else m_el++;
        M_WR:   if (m_el == WRC - 1) m_mode = M_IDLE; else m_el++;
        M_RET:  if (!ret_req) begin m_mode = M_REC; m_el = 0; end
        M_REC:  if (m_el == RDR - 1) m_mode = M_IDLE; else m_el++;
        default: m_mode = M_IDLE;
      endcase
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [6:0] ec;
    string tag;
    bit e_rdy;
    #3;
    cycles++;
    if (!rst_n) begin
      chk("R1", "reset pins", {25'd0, cs_n, cs, oe_n, we_n, ub_n, lb_n, dq_oe}, {25'd0, 7'b1111110});
      chk("R1", "reset rvalid", {31'd0, rvalid_o}, 32'd0);
    end else begin
      case (m_mode)
        M_RD: begin tag = "R2"; ec = {1'b0, 1'b1, 1'b0, 1'b1, ~c_be[1], ~c_be[0], 1'b0}; end
        M_WR: begin tag = "R3";
          ec = {1'b0, 1'b1, 1'b1, !(m_el >= 1 && m_el <= WP), ~c_be[1], ~c_be[0], 1'b1}; end
        M_TURN: begin tag = "R6"; ec = 7'b1111110; end
        M_RET:  begin tag = "R9"; ec = 7'b1011110; end
        M_REC:  begin tag = "R10"; ec = 7'b1111110; end
        default: begin tag = "R1"; ec = 7'b1111110; end
      endcase
      chk(tag, "mem pins", {25'd0, cs_n, cs, oe_n, we_n, ub_n, lb_n, dq_oe}, {25'd0, ec});
      e_rdy = (m_mode == M_IDLE) && !ret_req;
      chk((m_mode == M_IDLE && ret_req && req) ? "R11" : "R8", "ready",
          {31'd0, ready_o}, {31'd0, e_rdy});
      if (m_mode == M_RD || m_mode == M_WR) chk("R7", "address", {14'd0, maddr}, {14'd0, c_addr});
      if (m_mode == M_WR) chk("R4", "write data", {16'd0, dq_o}, {16'd0, c_wd});
      chk("R5", "rvalid", {31'd0, rvalid_o}, {31'd0, m_rv});
      if (m_rv) chk("R5", "rdata", {16'd0, rdata_o}, {16'd0, m_rd});
      // memory model: store enabled bytes under the write strobe
      if (!we_n && !cs_n && cs) begin
        if (!ub_n) mem_arr[maddr[5:0]][15:8] = dq_o[15:8];
        if (!lb_n) mem_arr[maddr[5:0]][7:0]  = dq_o[7:0];
      end
    end
    if (cycles > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired: actual hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic access(input bit w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = b;
    forever begin
      @(negedge clk);
      if (m_acc) break;
    end
    req = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_mode != M_IDLE) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_arr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 R3 R4 R5 R6 R7: word write and read-back
    access(1'b1, 18'd3, 16'h1234, 2'b11);
    access(1'b0, 18'd3, 16'h0, 2'b11);
    // R3: lower byte write, then single-lane reads for R5 masking
    access(1'b1, 18'd3, 16'hABCD, 2'b01);
    access(1'b0, 18'd3, 16'h0, 2'b10);
    access(1'b0, 18'd3, 16'h0, 2'b01);
    // R3: no byte enables, memory must stay 12CD
    access(1'b1, 18'd3, 16'hFFFF, 2'b00);
    access(1'b0, 18'd3, 16'h0, 2'b11);
    // R8: request while busy is dropped, addr 5 stays zero
    access(1'b0, 18'd7, 16'h0, 2'b11);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 18'd5; wdata = 16'hFFFF; be = 2'b11;
    @(negedge clk); req = 1'b0;
    wait_idle();
    access(1'b0, 18'd5, 16'h0, 2'b11);
    // write then read at another address, upper lane
    access(1'b1, 18'd9, 16'h9E3C, 2'b10);
    access(1'b0, 18'd9, 16'h0, 2'b11);
    // R9 R10: plain retention
    wait_idle();
    ret_req = 1'b1;
    repeat (10) @(negedge clk);
    ret_req = 1'b0;
    access(1'b0, 18'd3, 16'h0, 2'b11);
    // R11: request and retention in the same idle cycle
    wait_idle();
    ret_req = 1'b1; req = 1'b1; we = 1'b0; addr = 18'd9; be = 2'b11;
    repeat (4) @(negedge clk);
    ret_req = 1'b0;
    forever begin
      @(negedge clk);
      if (m_acc) break;
    end
    req = 1'b0;
    // R9: retention raised mid-read waits for read and turnaround
    access(1'b0, 18'd3, 16'h0, 2'b01);
    ret_req = 1'b1;
    repeat (15) @(negedge clk);
    ret_req = 1'b0;
    wait_idle();
    access(1'b1, 18'd3, 16'h5555, 2'b11);
    access(1'b0, 18'd3, 16'h0, 2'b11);
    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule